// File: doc/BRIEF.md
# SPI Master Serial Clock Divider

This block derives the serial clock timing for an SPI master from the module clock. Two 3-bit fields set the ratio. A linear prescale field `pre_sel` gives a factor from 1 to 8. A binary field `rate_sel` gives a factor from 2 to 256. The overall ratio is (pre_sel + 1) × 2^(rate_sel + 1). Because the two stages multiply, ratios that are not powers of two are available, such as 6, 10, 12 and 40. The largest ratio is 2048.

The divider runs only while the master flag and the transfer flag are both high. At all other times its counter is held at zero and the serial clock level sits low, so the divider draws no switching power when idle. Each transfer starts from the same phase.

The block has two outputs. `half_tick` is a one-cycle strobe that marks every half period. `sclk_div` is a 50 % duty level that flips on the clock edge after each strobe. The shift logic downstream can use either one. While the divider is idle, the ratio fields are sampled every cycle. Once a transfer is running, the sampled ratio is frozen, so a field write made during a transfer applies from the next transfer.

Top module: `sbd_baud_divider`

## Requirements
- R1: While running, `half_tick` is high in exactly one module clock out of every H, where H = (pre_sel + 1) × 2^rate_sel, which is half the divisor. The first strobe comes H cycles after the transfer starts, counting the start cycle itself.
- R2: `sclk_div` flips on the clock edge that follows each `half_tick` and holds at every other edge, giving a period equal to the full divisor with 50 % duty.
- R3: With pre_sel = 0 and rate_sel = 0, the divisor is 2: `half_tick` is high every running cycle and `sclk_div` flips at every edge.
- R4: Non-power-of-two divisors are reached: pre_sel = 2 with rate_sel = 0 gives 6, and pre_sel = 4 with rate_sel = 0 gives 10.
- R5: If either `master_en` or `xfer_active` is low, `half_tick` stays low and `sclk_div` stays low, whatever the fields are.
- R6: When running stops, `sclk_div` is low after the next clock edge. A transfer that starts again gets its first strobe after a full H cycles.
- R7: A change to `pre_sel` or `rate_sel` during a transfer does not change that transfer's timing. The new value is used by the next transfer.
- R8: A synchronous reset (`rst` high at a clock edge) drives `sclk_div` low and clears the count. If the run flags stay high through reset, the transfer restarts from a clean phase when `rst` falls.
- R9: The largest setting (pre_sel = 7, rate_sel = 7, divisor 2048) strobes every 1024 cycles with no counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_sel | input | 3 | Linear prescale field; factor is value + 1 |
| rate_sel | input | 3 | Binary stage field; factor is 2^(value + 1) |
| master_en | input | 1 | Block is configured as bus master |
| xfer_active | input | 1 | A serial transfer is in progress |
| half_tick | output | 1 | One-cycle strobe at each serial clock half period |
| sclk_div | output | 1 | Divided serial clock level, low when idle |

## Verification
The bench compares the strobe position and the clock level cycle by cycle against a divisor table, including divide by 2 and divide by 2048. A divider that gets the first of these wrong never lets the strobe fall. One that gets the second wrong shows a counter that overflows or is off by one. The bench writes new field values in the middle of a transfer, which catches a design that retimes instantly instead of waiting for the next transfer. It drops the run flags while the clock level is high, which catches a divider that freezes its clock level or count instead of returning them to idle. It also applies reset with the run flags still high, which catches a design that starts the next transfer with a short first half period.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int PRE_W    = 3;
  localparam int SEL_W    = 3;
  // Largest half period: max prescale factor times half of max binary factor
  localparam int MAX_HALF = (1 << PRE_W) << ((1 << SEL_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF + 1);

  typedef logic [PRE_W-1:0] pre_t;
  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // Half of the full divisor: (pre + 1) * 2^sel
  function automatic cnt_t half_period(input pre_t pre, input sel_t sel);
    cnt_t base;
    base = cnt_t'(pre) + cnt_t'(1);
    return base << sel;
  endfunction
endpackage

// File: rtl/sbd_rate_latch.sv
module sbd_rate_latch
  import sbd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  pre_t pre_sel,
  input  sel_t rate_sel,
  output cnt_t half_q
);
  // Track the fields while idle or in reset; hold them while a transfer runs
  always_ff @(posedge clk) begin
    if (rst || !run) half_q <= half_period(pre_sel, rate_sel);
  end

  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && !$past(rst) |-> $stable(half_q)); // R7
endmodule

// File: rtl/sbd_half_counter.sv
module sbd_half_counter
  import sbd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  cnt_t half_q,
  output logic tick
);
  cnt_t cnt;
  cnt_t last;

  assign last = half_q - cnt_t'(1);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + cnt_t'(1);
  end

  AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (rst)
    cnt < half_q); // R9
  AST_CNT_CLEAN_START: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> cnt == '0); // R6
endmodule

// File: rtl/sbd_sclk_gen.sv
module sbd_sclk_gen (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic sclk
);
  always_ff @(posedge clk) begin
    if (rst || !run) sclk <= 1'b0;
    else if (tick)   sclk <= ~sclk;
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sclk); // R6
endmodule

// File: rtl/sbd_baud_divider.sv
module sbd_baud_divider
  import sbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             master_en,
  input  logic             xfer_active,
  output logic             half_tick,
  output logic             sclk_div
);
  logic run;
  cnt_t half_q;

  assign run = master_en && xfer_active;

  sbd_rate_latch u_latch (
    .clk(clk), .rst(rst), .run(run),
    .pre_sel(pre_sel), .rate_sel(rate_sel), .half_q(half_q)
  );

  sbd_half_counter u_cnt (
    .clk(clk), .rst(rst), .run(run), .half_q(half_q), .tick(half_tick)
  );

  sbd_sclk_gen u_sclk (
    .clk(clk), .rst(rst), .run(run), .tick(half_tick), .sclk(sclk_div)
  );

  AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && !$past(rst) && !$past(half_tick) |-> $stable(sclk_div)); // R2
  AST_SCLK_FLIP: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) && !$past(rst) && $past(half_tick) |-> sclk_div != $past(sclk_div)); // R2
endmodule

// File: tb/sim_sbd_baud_divider.sv
module sim_sbd_baud_divider;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic [2:0] pre = 3'd0;
  logic [2:0] sel = 3'd0;
  logic       master = 1'b0;
  logic       xfer = 1'b0;
  logic       tick;
  logic       sclk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  sbd_baud_divider u0 (
    .clk(clk), .rst(rst), .pre_sel(pre), .rate_sel(sel),
    .master_en(master), .xfer_active(xfer),
    .half_tick(tick), .sclk_div(sclk)
  );

  // {pre, sel, full divisor}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {3'd0, 3'd0, 12'd2},    {3'd0, 3'd1, 12'd4},   {3'd0, 3'd2, 12'd8},
    {3'd1, 3'd0, 12'd4},    {3'd2, 3'd0, 12'd6},   {3'd4, 3'd0, 12'd10},
    {3'd2, 3'd1, 12'd12},   {3'd1, 3'd2, 12'd16},  {3'd6, 3'd3, 12'd112},
    {3'd7, 3'd7, 12'd2048}, {3'd0, 3'd7, 12'd256}, {3'd4, 3'd2, 12'd40}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at negedge+1; sample index i counts cycles since the run started
  task automatic walk(input int half, input int first, input int last,
                      input string tt, input string ts);
    int bad_t = 0, bad_s = 0, at = 0, et = 0, as_ = 0, es = 0;
    for (int i = first; i < last; i++) begin
      int e_t, e_s;
      e_t = ((i % half) == half - 1) ? 1 : 0;
      e_s = (i / half) % 2;
      if (tick !== e_t[0]) begin
        if (bad_t == 0) begin at = int'(tick); et = e_t; end
        bad_t++;
      end
      if (sclk !== e_s[0]) begin
        if (bad_s == 0) begin as_ = int'(sclk); es = e_s; end
        bad_s++;
      end
      @(negedge clk); #1;
    end
    check(bad_t == 0, {tt, " strobe"}, at, et);
    check(bad_s == 0, {ts, " level"}, as_, es);
  endtask

  task automatic start_run();
    @(negedge clk);
    master = 1'b1;
    xfer   = 1'b1;
    #1;
  endtask

  task automatic idle_with(input logic [2:0] p, input logic [2:0] s);
    @(negedge clk);
    master = 1'b0;
    xfer   = 1'b0;
    pre    = p;
    sel    = s;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(tick === 1'b0 && sclk === 1'b0, "R8 reset state", int'({tick, sclk}), 0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk: R1 strobe spacing, R2 level, R3/R4/R9 special ratios
    for (int v = 0; v < NV; v++) begin
      logic [17:0] e;
      int d;
      string tg;
      e  = VEC[v];
      d  = int'(e[11:0]);
      tg = (d == 2) ? "R3" : (d == 6 || d == 10) ? "R4" : (d == 2048) ? "R9" : "R1";
      idle_with(e[17:15], e[14:12]);
      start_run();
      walk(d / 2, 0, 2 * d + 3, tg, "R2");
    end

    // R5: frozen unless both flags are high
    begin
      int seen;
      idle_with(3'd0, 3'd0);
      master = 1'b0; xfer = 1'b1;
      seen = 0;
      repeat (40) begin
        @(negedge clk); #1;
        if (tick !== 1'b0 || sclk !== 1'b0) seen++;
      end
      check(seen == 0, "R5 slave flag blocks", seen, 0);
      master = 1'b1; xfer = 1'b0;
      seen = 0;
      repeat (40) begin
        @(negedge clk); #1;
        if (tick !== 1'b0 || sclk !== 1'b0) seen++;
      end
      check(seen == 0, "R5 no transfer blocks", seen, 0);
    end

    // R7: fields written mid transfer are ignored for that transfer
    idle_with(3'd0, 3'd1);
    start_run();
    walk(2, 0, 9, "R7", "R7");
    pre = 3'd7;
    sel = 3'd7;
    walk(2, 9, 30, "R7", "R7");

    // R5/R6: stop while level is high (index 30 -> level 1)
    master = 1'b0;
    #1;
    check(tick === 1'b0, "R5 strobe drops with run", int'(tick), 0);
    @(negedge clk); #1;
    check(sclk === 1'b0, "R6 level idles", int'(sclk), 0);

    // R6/R7: restart with new fields, clean first half period
    idle_with(3'd2, 3'd0);
    start_run();
    walk(3, 0, 14, "R6", "R7");

    // R8: reset while running restarts from a clean phase
    idle_with(3'd1, 3'd1);
    start_run();
    walk(4, 0, 6, "R8", "R8");
    rst = 1'b1;
    @(negedge clk); #1;
    check(sclk === 1'b0 && tick === 1'b0, "R8 reset mid run", int'({tick, sclk}), 0);
    rst = 1'b0;
    #1;
    walk(4, 0, 14, "R8", "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule